// File: doc/BRIEF.md
# Two-Thread Alternating Allocation Selector

This block decides which of two hardware threads may use a shared pipeline stage in each clock cycle. Typical users are a decoded-instruction cache port or the allocation stage of an out-of-order core. Each thread presents four status bits: a request, a flag that its input queue holds work, and two full flags, one for its reorder-buffer share and one for its reservation-station share. A thread is eligible only when it requests, its queue is not empty and neither of its shares is full.

A turn pointer records whose turn it is. The thread whose turn it is wins if it is eligible. If it is not, the other thread wins when that thread is eligible. A stalled thread therefore gives up its slot at once, and a lone eligible thread gets every cycle. The pointer advances only when the thread holding the turn is actually served. A thread that was skipped keeps its claim on the next slot it can use.

The grant is registered. Status bits sampled at one rising edge produce the grant that is visible after that edge. The turn pointer updates at the same edge.

Top module: `tsel_alloc_sel`

## Requirements
- R1: A synchronous active-high reset clears the grant to zero and sets the turn pointer to thread 0 (turn_o = 0).
- R2: A thread whose request bit is low is never granted, whatever its other status bits are.
- R3: A thread whose queue-not-empty bit is low is never granted.
- R4: A thread is never granted while its reorder-buffer full bit or its reservation-station full bit is high.
- R5: When both threads are eligible on successive edges, the grant alternates between them, starting with the thread that holds the turn.
- R6: When exactly one thread is eligible, that thread is granted on that edge regardless of the turn pointer.
- R7: The turn pointer toggles only when the thread it names is granted. When that thread is skipped and the other thread is served, the pointer keeps its value.
- R8: When neither thread is eligible, the grant is zero and the turn pointer holds.
- R9: grant_o is one-hot or zero. Bit i stands for thread i. The grant reflects the status bits sampled at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 2 | Per-thread request; bit i is thread i |
| qne_i | input | 2 | Per-thread input queue not empty |
| rob_full_i | input | 2 | Per-thread reorder-buffer share full |
| rs_full_i | input | 2 | Per-thread reservation-station share full |
| grant_o | output | 2 | Registered one-hot grant, or zero |
| turn_o | output | 1 | Turn pointer: 0 = thread 0, 1 = thread 1 |

## Verification
The bench targets the skip-and-keep-turn case. A blocked turn holder must lose its slot but keep the pointer. A design that toggles on every grant would hand the next shared cycle to the wrong thread, and one that waits for the turn holder would leave the stage idle. Each disqualifying bit is driven on its own, so a missed term in the eligibility AND shows up as a grant to a stalled thread. The idle case checks that the pointer does not drift when nobody is served. A mid-run reset checks that the pointer returns to thread 0.

// File: rtl/tsel_pkg.sv
package tsel_pkg;

    localparam int THR_N = 2;
    localparam int THR_W = $clog2(THR_N);

    typedef logic [THR_W-1:0] thr_id_t;

    typedef struct packed {
        logic req;
        logic qne;
        logic rob_full;
        logic rs_full;
    } thr_stat_t;

    typedef struct packed {
        logic    valid;
        thr_id_t id;
    } pick_t;

    function automatic thr_id_t other_thr(thr_id_t t);
        return thr_id_t'(THR_N - 1) - t;
    endfunction

    function automatic logic [THR_N-1:0] pick_onehot(pick_t p);
        logic [THR_N-1:0] v;
        v = '0;
        if (p.valid) v[p.id] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/tsel_elig.sv
module tsel_elig
    import tsel_pkg::*;
(
    input  thr_stat_t st,
    output logic      elig
);
    logic has_space;

    always_comb begin
        has_space = !st.rob_full && !st.rs_full;
        elig      = st.req && st.qne && has_space;
    end
endmodule

// File: rtl/tsel_pick.sv
module tsel_pick
    import tsel_pkg::*;
(
    input  logic [THR_N-1:0] elig,
    input  thr_id_t          turn,
    output pick_t            pick
);
    thr_id_t alt;

    always_comb begin
        alt  = other_thr(turn);
        pick = '0;
        if (elig[turn]) begin
            pick.valid = 1'b1;
            pick.id    = turn;
        end else if (elig[alt]) begin
            pick.valid = 1'b1;
            pick.id    = alt;
        end
    end
endmodule

// File: rtl/tsel_turn.sv
module tsel_turn
    import tsel_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  pick_t            pick,
    output logic [THR_N-1:0] grant_q,
    output thr_id_t          turn_q
);
    logic served_turn;

    always_comb served_turn = pick.valid && (pick.id == turn_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q <= '0;
            turn_q  <= '0;
        end else begin
            grant_q <= pick_onehot(pick);
            if (served_turn) turn_q <= other_thr(turn_q);
        end
    end

    AST_TURN_KEPT_ON_SKIP: assert property (@(posedge clk) disable iff (rst)
        (pick.valid && pick.id != turn_q) |=> $stable(turn_q)); // R7
    AST_TURN_HELD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!pick.valid) |=> ($stable(turn_q) && grant_q == '0)); // R8
endmodule

// File: rtl/tsel_alloc_sel.sv
module tsel_alloc_sel
    import tsel_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [THR_N-1:0] req_i,
    input  logic [THR_N-1:0] qne_i,
    input  logic [THR_N-1:0] rob_full_i,
    input  logic [THR_N-1:0] rs_full_i,
    output logic [THR_N-1:0] grant_o,
    output thr_id_t          turn_o
);
    logic [THR_N-1:0] elig;
    pick_t            pick;
    thr_id_t          turn;

    for (genvar g = 0; g < THR_N; g++) begin : g_thr
        thr_stat_t st;
        always_comb begin
            st.req      = req_i[g];
            st.qne      = qne_i[g];
            st.rob_full = rob_full_i[g];
            st.rs_full  = rs_full_i[g];
        end
        tsel_elig u_elig (.st(st), .elig(elig[g]));

        AST_GRANT_NEEDS_ELIG: assert property (@(posedge clk) disable iff (rst)
            (!(req_i[g] && qne_i[g] && !rob_full_i[g] && !rs_full_i[g])) |=> !grant_o[g]); // R4
    end

    tsel_pick u_pick (.elig(elig), .turn(turn), .pick(pick));

    tsel_turn u_turn (
        .clk(clk), .rst(rst), .pick(pick),
        .grant_q(grant_o), .turn_q(turn)
    );

    assign turn_o = turn;

    AST_GRANT_ONEHOT0: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o)); // R9
    AST_SOLE_ELIG_WINS: assert property (@(posedge clk) disable iff (rst)
        ($countones(elig) == 1) |=> (grant_o == $past(elig))); // R6
    AST_BOTH_ALTERNATE: assert property (@(posedge clk) disable iff (rst)
        (&elig) |=> (turn_o != $past(turn_o))); // R5
endmodule

// File: tb/tsel_alloc_sel_tb.sv
module tsel_alloc_sel_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] req_i = '0, qne_i = '0, rob_full_i = '0, rs_full_i = '0;
    logic [1:0] grant_o;
    logic       turn_o;
    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    tsel_alloc_sel u_dut (
        .clk(clk), .rst(rst), .req_i(req_i), .qne_i(qne_i),
        .rob_full_i(rob_full_i), .rs_full_i(rs_full_i),
        .grant_o(grant_o), .turn_o(turn_o)
    );

    task automatic check(input logic [1:0] eg, input logic et, input string tag);
        checks++;
        if (grant_o !== eg || turn_o !== et) begin
            errors++;
            $display("FAIL %s: grant=%b turn=%b expected grant=%b turn=%b",
                     tag, grant_o, turn_o, eg, et);
        end
        checks++;
        if (!$onehot0(grant_o)) begin
            errors++;
            $display("FAIL R9: grant=%b expected one-hot or zero", grant_o);
        end
    endtask

    // drive at negedge, let one rising edge pass, check at next negedge
    task automatic step(input logic [1:0] rq, input logic [1:0] qn,
                        input logic [1:0] rb, input logic [1:0] rs,
                        input logic [1:0] eg, input logic et, input string tag);
        req_i = rq; qne_i = qn; rob_full_i = rb; rs_full_i = rs;
        @(posedge clk);
        @(negedge clk);
        check(eg, et, tag);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        step(2'b11, 2'b11, 2'b00, 2'b00, 2'b00, 1'b0, "R1 reset");
        rst = 1'b0;
    endtask

    task automatic t_alternate;
        step(2'b11, 2'b11, 2'b00, 2'b00, 2'b01, 1'b1, "R5 alt c1");
        step(2'b11, 2'b11, 2'b00, 2'b00, 2'b10, 1'b0, "R5 alt c2");
        step(2'b11, 2'b11, 2'b00, 2'b00, 2'b01, 1'b1, "R5 alt c3");
        step(2'b11, 2'b11, 2'b00, 2'b00, 2'b10, 1'b0, "R5 alt c4");
    endtask

    task automatic t_queue_empty;
        step(2'b11, 2'b10, 2'b00, 2'b00, 2'b10, 1'b0, "R3 R6 R7 q0 empty a");
        step(2'b11, 2'b10, 2'b00, 2'b00, 2'b10, 1'b0, "R3 R6 R7 q0 empty b");
        step(2'b11, 2'b10, 2'b00, 2'b00, 2'b10, 1'b0, "R3 R6 R7 q0 empty c");
        step(2'b11, 2'b11, 2'b00, 2'b00, 2'b01, 1'b1, "R7 skipped thread first");
    endtask

    task automatic t_full_flags;
        step(2'b11, 2'b11, 2'b10, 2'b00, 2'b01, 1'b1, "R4 rob1 full");
        step(2'b11, 2'b11, 2'b00, 2'b10, 2'b01, 1'b1, "R4 rs1 full");
        step(2'b11, 2'b11, 2'b00, 2'b00, 2'b10, 1'b0, "R7 t1 served after skip");
        step(2'b11, 2'b11, 2'b01, 2'b00, 2'b10, 1'b0, "R4 rob0 full");
        step(2'b11, 2'b11, 2'b00, 2'b01, 2'b10, 1'b0, "R4 rs0 full");
    endtask

    task automatic t_no_request;
        step(2'b00, 2'b11, 2'b00, 2'b00, 2'b00, 1'b0, "R2 R8 no req");
        step(2'b10, 2'b11, 2'b00, 2'b00, 2'b10, 1'b0, "R2 req0 low");
    endtask

    task automatic t_idle;
        step(2'b11, 2'b11, 2'b00, 2'b00, 2'b01, 1'b1, "R5 set turn 1");
        step(2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 1'b1, "R8 idle a");
        step(2'b11, 2'b11, 2'b11, 2'b11, 2'b00, 1'b1, "R8 idle b");
        step(2'b11, 2'b11, 2'b00, 2'b00, 2'b10, 1'b0, "R8 turn kept after idle");
    endtask

    task automatic t_mid_reset;
        step(2'b11, 2'b11, 2'b00, 2'b00, 2'b01, 1'b1, "R5 before reset");
        rst = 1'b1;
        step(2'b11, 2'b11, 2'b00, 2'b00, 2'b00, 1'b0, "R1 mid-run reset");
        rst = 1'b0;
        step(2'b11, 2'b11, 2'b00, 2'b00, 2'b01, 1'b1, "R1 t0 first after reset");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_alternate();
        t_queue_empty();
        t_full_flags();
        t_no_request();
        t_idle();
        t_mid_reset();
        done = 1;
    end

    initial begin
        for (int i = 0; i < 2000 && !done; i++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule